// File: doc/BRIEF.md
# Core Wrapper Serial Port

This block gives a scan path into an embedded core. Every scan passes through a one-bit path selector stage. Behind that stage sits one of two targets. The first is a 4-bit wrapper instruction register. The second is a data-register mux driven by the decoded instruction. The mux chooses among three registers: a one-bit bypass stage, an 8-bit boundary register and a 6-bit self-test control register.

The path selector only takes a new value on an update strobe. Because of this, a scan in progress always runs over the path it started on. Test software first scans a 1 into the selector. It then scans a new instruction together with a selector value of 0. It then scans the chosen data register.

Shift, capture and update strobes, an active-low reset and the test clock drive every register. Only the segment on the current path reacts to these strobes.

Top module: `wsp_top`

## Requirements
- R1: An active-low reset clears the selector to 0, clears the instruction to 0000 and clears all shift and update stages. After reset the path is the two-bit chain selector-plus-bypass, and the boundary and self-test parallel outputs read 0.
- R2: The serial order is `wsi` → selector shift stage → selected segment, most significant bit first → segment bit 0 → `wso`. The selector's update stage decides the path: 1 selects the instruction register and 0 selects the data mux. That update stage changes only on an update strobe, so the path stays fixed for a whole scan.
- R3: The instruction register is 4 bits wide. On capture it reloads its current instruction, so reading it back leaves it unchanged. On capture the selector shift stage loads the selector's current value.
- R4: Codes 0001 and 0010 select the 8-bit boundary register. On capture it loads `bndCapIn`, and on update it drives `bndPo`.
- R5: Code 0100 selects the 6-bit self-test register. On capture it loads `bistCapIn`, and on update it drives `bistPo`.
- R6: Code 0000, every code with bit 3 set, and every other unlisted code select the one-bit bypass stage. This stage captures 0 and has no parallel output.
- R7: When capture and shift are both asserted in the same cycle, capture takes effect and shift is ignored.
- R8: Only the segment on the current path captures, shifts or updates. Every other segment holds both its stages.
- R9: A single update strobe can load a new instruction and clear the selector at once. The next scan then runs through the data register that the new instruction picks.
- R10: `bndPo` and `bistPo` change only on an update strobe while their own segment is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck | input | 1 | Test clock |
| wrstN | input | 1 | Active-low reset |
| wsi | input | 1 | Serial data in |
| shiftWr | input | 1 | Shift strobe |
| captureWr | input | 1 | Capture strobe |
| updateWr | input | 1 | Update strobe |
| bndCapIn | input | 8 | Boundary capture data |
| bistCapIn | input | 6 | Self-test status capture data |
| wso | output | 1 | Serial data out |
| bndPo | output | 8 | Boundary register update stage |
| bistPo | output | 6 | Self-test register update stage |

## Verification
Two events can land on the same edge. One is a selector update together with an instruction update: a single update strobe loads a new code and flips the selector. The bench provokes this by scanning an instruction with the selector bit 0. It judges the result by checking that the next scan has exactly the length of the newly chosen data register and returns its captured data. The other is capture together with shift. The bench asserts both strobes in one cycle, and the serial output must show the captured boundary bit and not a shifted one.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int WIR_W  = 4;
  localparam int BND_W  = 8;
  localparam int BIST_W = 6;

  localparam logic [WIR_W-1:0] OP_BYPASS = 4'b0000;
  localparam logic [WIR_W-1:0] OP_EXTEST = 4'b0001;
  localparam logic [WIR_W-1:0] OP_INTEST = 4'b0010;
  localparam logic [WIR_W-1:0] OP_BIST   = 4'b0100;

  typedef enum logic [1:0] {SEG_BYP, SEG_BND, SEG_BIST} segSel_e;

  typedef struct packed {
    logic shift;
    logic capture;
    logic update;
  } wspStb_t;

  // The top bit marks the parallel group; that group and unknown codes fall to bypass
  function automatic segSel_e decodeWir(input logic [WIR_W-1:0] code);
    if (code[WIR_W-1])                            return SEG_BYP;
    else if (code == OP_EXTEST || code == OP_INTEST) return SEG_BND;
    else if (code == OP_BIST)                        return SEG_BIST;
    else                                             return SEG_BYP;
  endfunction
endpackage

// File: rtl/wsp_ctrl.sv
module wsp_ctrl
  import wsp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    si,
  input  logic    shiftEn,
  input  logic    captureEn,
  input  logic    updateEn,
  output logic    chainOut,
  output logic    selWir,
  output logic    wirSo,
  output segSel_e segSel,
  output wspStb_t bypStb,
  output wspStb_t bndStb,
  output wspStb_t bistStb
);
  logic             selShift, selUpd;
  logic [WIR_W-1:0] wirShift, wirUpd;

  // Selector: always on the path; its update stage holds the routing for the scan
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selShift <= 1'b0;
      selUpd   <= 1'b0;
    end else begin
      if (captureEn)    selShift <= selUpd;
      else if (shiftEn) selShift <= si;
      if (updateEn)     selUpd   <= selShift;
    end
  end

  // Instruction register, active only while routed by the selector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wirShift <= OP_BYPASS;
      wirUpd   <= OP_BYPASS;
    end else if (selUpd) begin
      if (captureEn)    wirShift <= wirUpd;
      else if (shiftEn) wirShift <= {selShift, wirShift[WIR_W-1:1]};
      if (updateEn)     wirUpd   <= wirShift;
    end
  end

  assign chainOut = selShift;
  assign selWir   = selUpd;
  assign wirSo    = wirShift[0];
  assign segSel   = decodeWir(wirUpd);

  logic dataPath;
  assign dataPath = !selUpd;

  always_comb begin
    bypStb  = '0;
    bndStb  = '0;
    bistStb = '0;
    if (dataPath) begin
      unique case (segSel)
        SEG_BND:  bndStb  = '{shift: shiftEn, capture: captureEn, update: updateEn};
        SEG_BIST: bistStb = '{shift: shiftEn, capture: captureEn, update: updateEn};
        default:  bypStb  = '{shift: shiftEn, capture: captureEn, update: updateEn};
      endcase
    end
  end
endmodule

// File: rtl/wsp_seg.sv
module wsp_seg
  import wsp_pkg::*;
#(
  parameter int W       = 8,
  parameter bit HAS_UPD = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serIn,
  input  wspStb_t      stb,
  input  logic [W-1:0] capIn,
  output logic         serOut,
  output logic [W-1:0] parOut
);
  logic [W-1:0] shiftQ;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            shiftQ <= '0;
        else if (stb.capture) shiftQ <= capIn;
        else if (stb.shift)   shiftQ <= serIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            shiftQ <= '0;
        else if (stb.capture) shiftQ <= capIn;
        else if (stb.shift)   shiftQ <= {serIn, shiftQ[W-1:1]};
      end
    end

    if (HAS_UPD) begin : g_upd
      logic [W-1:0] updQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           updQ <= '0;
        else if (stb.update) updQ <= shiftQ;
      end
      assign parOut = updQ;
    end else begin : g_noupd
      logic unusedUpd;
      assign unusedUpd = stb.update;
      assign parOut    = '0;
    end
  endgenerate

  assign serOut = shiftQ[0];
endmodule

// File: rtl/wsp_data.sv
module wsp_data
  import wsp_pkg::*;
#(
  parameter int BND_N  = BND_W,
  parameter int BIST_N = BIST_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainIn,
  input  logic              selWir,
  input  logic              wirSo,
  input  segSel_e           segSel,
  input  wspStb_t           bypStb,
  input  wspStb_t           bndStb,
  input  wspStb_t           bistStb,
  input  logic [BND_N-1:0]  bndCapIn,
  input  logic [BIST_N-1:0] bistCapIn,
  output logic              so,
  output logic [BND_N-1:0]  bndPo,
  output logic [BIST_N-1:0] bistPo
);
  logic bypSo, bndSo, bistSo;
  logic unusedBypPo;

  wsp_seg #(.W(1), .HAS_UPD(1'b0)) u_byp (
    .clk(clk), .rstN(rstN), .serIn(chainIn), .stb(bypStb),
    .capIn(1'b0), .serOut(bypSo), .parOut(unusedBypPo)
  );

  wsp_seg #(.W(BND_N), .HAS_UPD(1'b1)) u_bnd (
    .clk(clk), .rstN(rstN), .serIn(chainIn), .stb(bndStb),
    .capIn(bndCapIn), .serOut(bndSo), .parOut(bndPo)
  );

  wsp_seg #(.W(BIST_N), .HAS_UPD(1'b1)) u_bist (
    .clk(clk), .rstN(rstN), .serIn(chainIn), .stb(bistStb),
    .capIn(bistCapIn), .serOut(bistSo), .parOut(bistPo)
  );

  always_comb begin
    if (selWir) so = wirSo;
    else begin
      unique case (segSel)
        SEG_BND:  so = bndSo;
        SEG_BIST: so = bistSo;
        default:  so = bypSo;
      endcase
    end
  end
endmodule

// File: rtl/wsp_top.sv
module wsp_top
  import wsp_pkg::*;
#(
  parameter int BND_N  = BND_W,
  parameter int BIST_N = BIST_W
) (
  input  logic              wrck,
  input  logic              wrstN,
  input  logic              wsi,
  input  logic              shiftWr,
  input  logic              captureWr,
  input  logic              updateWr,
  input  logic [BND_N-1:0]  bndCapIn,
  input  logic [BIST_N-1:0] bistCapIn,
  output logic              wso,
  output logic [BND_N-1:0]  bndPo,
  output logic [BIST_N-1:0] bistPo
);
  logic    chainOut, selWir, wirSo;
  segSel_e segSel;
  wspStb_t bypStb, bndStb, bistStb;

  wsp_ctrl u_ctrl (
    .clk(wrck), .rstN(wrstN), .si(wsi), .shiftEn(shiftWr),
    .captureEn(captureWr), .updateEn(updateWr), .chainOut(chainOut),
    .selWir(selWir), .wirSo(wirSo), .segSel(segSel),
    .bypStb(bypStb), .bndStb(bndStb), .bistStb(bistStb)
  );

  wsp_data #(.BND_N(BND_N), .BIST_N(BIST_N)) u_data (
    .clk(wrck), .rstN(wrstN), .chainIn(chainOut), .selWir(selWir),
    .wirSo(wirSo), .segSel(segSel), .bypStb(bypStb), .bndStb(bndStb),
    .bistStb(bistStb), .bndCapIn(bndCapIn), .bistCapIn(bistCapIn),
    .so(wso), .bndPo(bndPo), .bistPo(bistPo)
  );
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker
  import wsp_pkg::*;
#(
  parameter int BND_N  = BND_W,
  parameter int BIST_N = BIST_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              updateWr,
  input logic              selWir,
  input logic              wso,
  input wspStb_t           bypStb,
  input wspStb_t           bndStb,
  input wspStb_t           bistStb,
  input logic [BND_N-1:0]  bndPo,
  input logic [BIST_N-1:0] bistPo
);
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !updateWr |=> $stable(selWir))
    else $error("selector path changed without update");

  p_one_seg_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bypStb.shift, bndStb.shift, bistStb.shift}))
    else $error("more than one data segment shifting");

  p_wir_path_r8: assert property (@(posedge clk) disable iff (!rstN)
    selWir |-> !(bypStb.shift || bndStb.shift || bistStb.shift ||
                 bndStb.update || bistStb.update))
    else $error("data segment active while instruction path selected");

  p_byp_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bypStb.capture && !updateWr) |=> (wso == 1'b0))
    else $error("bypass did not capture zero");

  p_bnd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !bndStb.update |=> $stable(bndPo))
    else $error("boundary output moved without its update");

  p_bist_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !bistStb.update |=> $stable(bistPo))
    else $error("self-test output moved without its update");
endmodule

bind wsp_top wsp_checker #(.BND_N(BND_N), .BIST_N(BIST_N)) u_chk (
  .clk(wrck), .rstN(wrstN), .updateWr(updateWr), .selWir(selWir),
  .wso(wso), .bypStb(bypStb), .bndStb(bndStb), .bistStb(bistStb),
  .bndPo(bndPo), .bistPo(bistPo)
);

// File: tb/sim_wsp_top.sv
module sim_wsp_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       si = 1'b0, sh = 1'b0, cap = 1'b0, upd = 1'b0;
  logic [7:0] bndIn = '0;
  logic [5:0] bistIn = '0;
  logic       wso;
  logic [7:0] bndPo;
  logic [5:0] bistPo;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  wsp_top u0 (
    .wrck(clk), .wrstN(rstN), .wsi(si), .shiftWr(sh), .captureWr(cap),
    .updateWr(upd), .bndCapIn(bndIn), .bistCapIn(bistIn),
    .wso(wso), .bndPo(bndPo), .bistPo(bistPo)
  );

  // Behavioural reference state
  logic       mSel = 0, mSelU = 0, mByp = 0;
  logic [3:0] mWir = 0, mWirU = 0;
  logic [7:0] mBnd = 0, mBndU = 0;
  logic [5:0] mBist = 0, mBistU = 0;

  function automatic int target(input logic [3:0] c);
    if (c >= 8) return 0;
    if (c == 1 || c == 2) return 1;
    if (c == 4) return 2;
    return 0;
  endfunction

  function automatic logic expSo();
    int t;
    if (mSelU) return mWir[0];
    t = target(mWirU);
    if (t == 1) return mBnd[0];
    if (t == 2) return mBist[0];
    return mByp;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic doSh, input logic doCap, input logic doUpd);
    logic       oSel, oSelU, oByp;
    logic [3:0] oWir, oWirU;
    logic [7:0] oBnd;
    logic [5:0] oBist;
    int         t;
    si = s; sh = doSh; cap = doCap; upd = doUpd;
    @(posedge clk);
    oSel = mSel; oSelU = mSelU; oWir = mWir; oWirU = mWirU;
    oByp = mByp; oBnd = mBnd; oBist = mBist;
    t = target(oWirU);
    if (doCap) begin
      mSel = oSelU;
      if (oSelU) mWir = oWirU;
      else if (t == 1) mBnd = bndIn;
      else if (t == 2) mBist = bistIn;
      else mByp = 1'b0;
    end else if (doSh) begin
      mSel = s;
      if (oSelU) mWir = {oSel, oWir[3:1]};
      else if (t == 1) mBnd = {oSel, oBnd[7:1]};
      else if (t == 2) mBist = {oSel, oBist[5:1]};
      else mByp = oSel;
    end
    if (doUpd) begin
      mSelU = oSel;
      if (oSelU) mWirU = oWir;
      else if (t == 1) mBndU = oBnd;
      else if (t == 2) mBistU = oBist;
    end
    @(negedge clk);
    chk("R2 per-cycle wso", {31'd0, wso}, {31'd0, expSo()});
    chk("R10 per-cycle bndPo", {24'd0, bndPo}, {24'd0, mBndU});
    chk("R10 per-cycle bistPo", {26'd0, bistPo}, {26'd0, mBistU});
    si = 0; sh = 0; cap = 0; upd = 0;
  endtask

  task automatic scan(input int len, input logic [15:0] din, input bit doCap,
                      input bit doUpd, output logic [15:0] dout);
    dout = '0;
    if (doCap) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < len; i++) begin
      dout[i] = wso;
      cyc(din[i], 1'b1, 1'b0, 1'b0);
    end
    if (doUpd) cyc(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [15:0] o;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset bndPo", {24'd0, bndPo}, 32'd0);
    chk("R1 reset bistPo", {26'd0, bistPo}, 32'd0);
    chk("R1 reset wso", {31'd0, wso}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // reset path is selector + bypass; set selector to 1
    scan(2, 16'b10, 1, 1, o);
    chk("R1 reset path capture", {16'd0, o}, 32'b00);
    scan(5, 16'b10010, 1, 1, o);
    chk("R2 selector capture with reset instruction", {16'd0, o}, 32'b10000);
    // readback and, in the same update, new instruction + selector cleared
    scan(5, 16'b00001, 1, 1, o);
    chk("R3 non-destructive instruction readback", {16'd0, o}, 32'b10010);
    bndIn = 8'hA5;
    scan(9, 16'h03C, 1, 1, o);
    chk("R9 boundary path after joint update", {16'd0, o}, 32'h0A5);
    chk("R4 boundary update", {24'd0, bndPo}, 32'h3C);
    chk("R8 self-test output untouched", {26'd0, bistPo}, 32'h0);
    // capture and shift together
    bndIn = 8'h5A;
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R7 capture beats shift", {31'd0, wso}, 32'd0);
    scan(9, 16'h13C, 0, 1, o);
    chk("R7 captured word intact", {16'd0, o}, 32'h05A);
    scan(5, 16'b00100, 1, 1, o);
    chk("R3 readback of EXTEST code", {16'd0, o}, 32'b10001);
    bistIn = 6'h2B;
    scan(7, 16'h15, 1, 1, o);
    chk("R5 self-test capture", {16'd0, o}, 32'h2B);
    chk("R5 self-test update", {26'd0, bistPo}, 32'h15);
    chk("R8 boundary held during self-test scan", {24'd0, bndPo}, 32'h3C);
    scan(7, 16'h55, 1, 1, o);
    scan(5, 16'b01011, 1, 1, o);
    chk("R3 readback of BIST code", {16'd0, o}, 32'b10100);
    scan(2, 16'b01, 1, 1, o);
    chk("R6 parallel group selects bypass capturing 0", {16'd0, o}, 32'b00);
    scan(4, 16'b0011, 0, 1, o);
    chk("R6 bypass path length", {16'd0, o}, 32'b1101);
    chk("R6 no boundary effect", {24'd0, bndPo}, 32'h3C);
    chk("R6 no self-test effect", {26'd0, bistPo}, 32'h15);
    scan(2, 16'b10, 0, 1, o);
    scan(5, 16'b00011, 1, 1, o);
    chk("R3 readback of parallel code", {16'd0, o}, 32'b11011);
    scan(2, 16'b11, 1, 0, o);
    chk("R6 unlisted code selects bypass", {16'd0, o}, 32'b00);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule